// File: doc/BRIEF.md
# Masked vector compare-select unit

This unit executes one element-wise vector operation at a time, gated by a private mask register that holds one bit per element. Test operations compare the elements of two source vectors and write one mask bit per element. A flip operation complements the mask. Arithmetic and move operations produce one destination element per cycle on a write port, and a mask bit of zero suppresses the write for its element. A conditional select such as `c[i] = (a[i] >= b[i]) ? a[i] : b[i]` takes four operations: a signed compare, a masked move of the first source, a mask flip, and a masked move of the second source.

The unit addresses both source vectors through a single element index, `rd_idx`. The surrounding register file returns `rd_a` and `rd_b` combinationally in the same cycle. Each result leaves through `wr_en`, `wr_idx` and `wr_data` in that same cycle.

Arithmetic operations run in one of two modes:
- **Simple mode** visits every element below the active length in turn, and the mask only gates the write enable.
- **Density mode** jumps from one set mask bit to the next. Its run time follows the number of set bits, not the vector length.

The controller is a five-state machine.
- **IDLE** waits for `start`. On `start` it takes the *launch* transition to:
  - FLIP for the flip code;
  - SKIP for an arithmetic code with `density` high;
  - SCAN otherwise.
- **SCAN** steps an index upward from 0. It takes the *scan-end* transition to FIN on the last element.
- **SKIP** issues the lowest set mask bit at or above a cursor. It takes the *skip-end* transition to FIN when no further set bit remains.
- **FLIP** updates the mask in one cycle and takes the *flip-end* transition to FIN.
- **FIN** raises `done` for one cycle and takes the *return* transition to IDLE.

Top module: `vcs_unit`

## Requirements
- R1: After reset, `done` and `wr_en` are low and every mask bit is 0. A move issued next in simple mode therefore writes nothing.
- R2: Opcode 0 (zero test) sets mask bit i to 1 exactly when `rd_a` element i equals 0.
- R3: Opcode 1 (non-zero test) sets mask bit i to 1 exactly when `rd_a` element i is not 0.
- R4: Opcode 2 (signed test) sets mask bit i when element i of `rd_a` is greater than or equal to element i of `rd_b`, both read as two's-complement numbers.
- R5: Opcode 3 (flip) inverts every mask bit below the active length and clears the rest. It keeps the unit busy for exactly one cycle and writes nothing.
- R6: With `density` low, an arithmetic operation visits elements 0 to L-1 in ascending order, one per cycle. It asserts `wr_en` for element i exactly when mask bit i is 1. It stays busy for max(1, L) cycles.
- R7: With `density` high, an arithmetic operation issues only the elements below L whose mask bit is 1, in ascending order, one per cycle. It stays busy for max(1, number of such bits) cycles.
- R8: The write data is:
  - opcode 4: a+b modulo 2^EW;
  - opcode 5: the low EW bits of a*b;
  - opcode 6: a;
  - opcode 7: b.
- R9: The active length L is `vlen` sampled at launch and clamped to NUM_EL. No element at or above L is ever written, whatever its mask bit.
- R10: `done` is high for exactly one cycle, in the cycle after the last busy cycle. `start` has no effect while an operation is in progress.
- R11: Test operations ignore `density`, stay busy for max(1, L) cycles and never assert `wr_en`. Mask bits at or above L are cleared.
- R12: The four-operation sequence (signed test, masked move of a, flip, masked move of b) leaves the signed maximum of a[i] and b[i] in every destination element below L, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches an operation when the unit is idle |
| opcode | input | 3 | Operation code (0..7, see R2-R8) |
| density | input | 1 | 1 selects density mode for arithmetic operations |
| vlen | input | $clog2(NUM_EL+1) | Requested vector length, sampled at launch |
| rd_idx | output | $clog2(NUM_EL) | Element index presented to both source read ports |
| rd_a | input | EW | Element `rd_idx` of the first source vector |
| rd_b | input | EW | Element `rd_idx` of the second source vector |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | $clog2(NUM_EL) | Destination element index |
| wr_data | output | EW | Destination element value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume three things about the surroundings:
- the register file answers `rd_idx` in the same cycle, so `rd_a` and `rd_b` always belong to the element on `wr_idx`;
- the source vectors do not change while an operation is in flight;
- a `start` seen while idle is a real launch, which is how the checker tracks the active length and operation.

The bench respects these assumptions. It models both source vectors as arrays indexed continuously by `rd_idx`, and changes them only between operations. It also raises `start` mid-operation, once on purpose, to show that the unit ignores it.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

    typedef enum logic [2:0] {
        OP_EQZ  = 3'd0,
        OP_NEZ  = 3'd1,
        OP_GE   = 3'd2,
        OP_NOT  = 3'd3,
        OP_ADD  = 3'd4,
        OP_MUL  = 3'd5,
        OP_MOVA = 3'd6,
        OP_MOVB = 3'd7
    } vop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SKIP,
        ST_FLIP,
        ST_FIN
    } vst_e;

    function automatic logic is_test(vop_e op);
        return (op == OP_EQZ) || (op == OP_NEZ) || (op == OP_GE);
    endfunction

    function automatic logic is_arith(vop_e op);
        return (op == OP_ADD) || (op == OP_MUL) || (op == OP_MOVA) || (op == OP_MOVB);
    endfunction

endpackage

// File: rtl/vcs_lane_alu.sv
module vcs_lane_alu
    import vcs_pkg::*;
#(
    parameter int EW = 8
) (
    input  vop_e          op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] res,
    output logic          test_bit
);

    // Element result for arithmetic and move operations
    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_MUL:  res = a * b;
            OP_MOVB: res = b;
            default: res = a;
        endcase
    end

    // Element predicate for test operations
    always_comb begin
        case (op)
            OP_EQZ:  test_bit = (a == '0);
            OP_NEZ:  test_bit = (a != '0);
            OP_GE:   test_bit = ($signed(a) >= $signed(b));
            default: test_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/vcs_mask_reg.sv
module vcs_mask_reg #(
    parameter  int NUM_EL = 8,
    localparam int IDXW   = $clog2(NUM_EL),
    localparam int LENW   = $clog2(NUM_EL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_en,
    input  logic [IDXW-1:0]   set_idx,
    input  logic              set_val,
    input  logic              flip_en,
    input  logic [LENW-1:0]   len,
    output logic [NUM_EL-1:0] mask
);

    for (genvar i = 0; i < NUM_EL; i++) begin : g_bit
        logic below_len;
        assign below_len = LENW'(i) < len;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[i] <= 1'b0;
            end else if (clr) begin
                mask[i] <= 1'b0;
            end else if (flip_en) begin
                mask[i] <= below_len ? ~mask[i] : 1'b0;
            end else if (set_en && (set_idx == IDXW'(i))) begin
                mask[i] <= set_val;
            end
        end
    end

endmodule

// File: rtl/vcs_elem_pick.sv
module vcs_elem_pick #(
    parameter  int NUM_EL = 8,
    localparam int IDXW   = $clog2(NUM_EL),
    localparam int LENW   = $clog2(NUM_EL + 1)
) (
    input  logic [NUM_EL-1:0] mask,
    input  logic [LENW-1:0]   cursor,
    input  logic [LENW-1:0]   len,
    output logic              found,
    output logic [IDXW-1:0]   pos,
    output logic              more
);

    logic [NUM_EL-1:0] cand;
    logic [NUM_EL-1:0] lowest;

    // An element is a candidate when its mask bit is set inside [cursor, len)
    for (genvar i = 0; i < NUM_EL; i++) begin : g_cand
        assign cand[i] = mask[i] && (LENW'(i) >= cursor) && (LENW'(i) < len);
    end

    assign lowest = cand & (~cand + NUM_EL'(1));
    assign found  = |cand;
    assign more   = |(cand & ~lowest);

    always_comb begin
        pos = '0;
        for (int i = NUM_EL - 1; i >= 0; i--) begin
            if (cand[i]) pos = IDXW'(i);
        end
    end

endmodule

// File: rtl/vcs_unit.sv
module vcs_unit
    import vcs_pkg::*;
#(
    parameter  int NUM_EL = 8,
    parameter  int EW     = 8,
    localparam int IDXW   = $clog2(NUM_EL),
    localparam int LENW   = $clog2(NUM_EL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      opcode,
    input  logic            density,
    input  logic [LENW-1:0] vlen,
    output logic [IDXW-1:0] rd_idx,
    input  logic [EW-1:0]   rd_a,
    input  logic [EW-1:0]   rd_b,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [EW-1:0]   wr_data,
    output logic            done
);

    vst_e            state_q, state_d;
    vop_e            op_q;
    vop_e            op_in;
    logic [LENW-1:0] len_q;
    logic [LENW-1:0] cur_q;
    logic [IDXW-1:0] idx_q;
    logic [LENW-1:0] len_clamp;

    logic [NUM_EL-1:0] mask;
    logic              pick_found;
    logic              pick_more;
    logic [IDXW-1:0]   pick_pos;
    logic [EW-1:0]     alu_res;
    logic              alu_test;
    logic              in_range;
    logic              scan_last;
    logic              m_clr;
    logic              m_set;
    logic              m_flip;

    assign op_in     = vop_e'(opcode);
    assign len_clamp = (vlen > LENW'(NUM_EL)) ? LENW'(NUM_EL) : vlen;
    assign in_range  = LENW'(idx_q) < len_q;
    assign scan_last = (LENW'(idx_q) + LENW'(1)) >= len_q;

    vcs_lane_alu #(.EW(EW)) u_alu (
        .op       (op_q),
        .a        (rd_a),
        .b        (rd_b),
        .res      (alu_res),
        .test_bit (alu_test)
    );

    vcs_mask_reg #(.NUM_EL(NUM_EL)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (m_clr),
        .set_en  (m_set),
        .set_idx (idx_q),
        .set_val (alu_test),
        .flip_en (m_flip),
        .len     (len_q),
        .mask    (mask)
    );

    vcs_elem_pick #(.NUM_EL(NUM_EL)) u_pick (
        .mask   (mask),
        .cursor (cur_q),
        .len    (len_q),
        .found  (pick_found),
        .pos    (pick_pos),
        .more   (pick_more)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (op_in == OP_NOT)                 state_d = ST_FLIP;
                    else if (is_arith(op_in) && density) state_d = ST_SKIP;
                    else                                 state_d = ST_SCAN;
                end
            end
            ST_SCAN: if (scan_last)  state_d = ST_FIN;
            ST_SKIP: if (!pick_more) state_d = ST_FIN;
            ST_FLIP: state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_EQZ;
            len_q   <= '0;
            idx_q   <= '0;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                op_q  <= op_in;
                len_q <= len_clamp;
                idx_q <= '0;
                cur_q <= '0;
            end
            if (state_q == ST_SCAN) idx_q <= idx_q + IDXW'(1);
            if (state_q == ST_SKIP) cur_q <= LENW'(pick_pos) + LENW'(1);
        end
    end

    // Outputs and mask controls
    always_comb begin
        rd_idx = (state_q == ST_SKIP) ? pick_pos : idx_q;
        wr_en  = 1'b0;
        done   = 1'b0;
        m_clr  = 1'b0;
        m_set  = 1'b0;
        m_flip = 1'b0;
        unique case (state_q)
            ST_IDLE: m_clr = start && is_test(op_in);
            ST_SCAN: begin
                wr_en = is_arith(op_q) && in_range && mask[idx_q];
                m_set = is_test(op_q) && in_range;
            end
            ST_SKIP: wr_en  = pick_found;
            ST_FLIP: m_flip = 1'b1;
            ST_FIN:  done   = 1'b1;
            default: ;
        endcase
        wr_idx  = rd_idx;
        wr_data = alu_res;
    end

endmodule

// File: rtl/vcs_unit_chk.sv
module vcs_unit_chk #(
    parameter  int NUM_EL = 8,
    parameter  int EW     = 8,
    localparam int IDXW   = $clog2(NUM_EL),
    localparam int LENW   = $clog2(NUM_EL + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [2:0]      opcode,
    input logic [LENW-1:0] vlen,
    input logic [EW-1:0]   rd_a,
    input logic [EW-1:0]   rd_b,
    input logic            wr_en,
    input logic [IDXW-1:0] wr_idx,
    input logic [EW-1:0]   wr_data,
    input logic            done
);

    logic            busy_c;
    logic [LENW-1:0] len_c;
    logic [2:0]      op_c;
    logic            have_last;
    logic [IDXW-1:0] last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c    <= 1'b0;
            len_c     <= '0;
            op_c      <= '0;
            have_last <= 1'b0;
            last_idx  <= '0;
        end else if (start && !busy_c) begin
            busy_c    <= 1'b1;
            len_c     <= (vlen > LENW'(NUM_EL)) ? LENW'(NUM_EL) : vlen;
            op_c      <= opcode;
            have_last <= 1'b0;
        end else begin
            if (done) busy_c <= 1'b0;
            if (wr_en) begin
                have_last <= 1'b1;
                last_idx  <= wr_idx;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_c |-> (!wr_en && !done));

    p_write_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && have_last) |-> (wr_idx > last_idx));

    p_add_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_c == 3'd4) |-> (wr_data == EW'(rd_a + rd_b)));

    p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (LENW'(wr_idx) < len_c));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    p_mask_op_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_c && op_c <= 3'd3) |-> !wr_en);

endmodule

bind vcs_unit vcs_unit_chk #(.NUM_EL(NUM_EL), .EW(EW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opcode  (opcode),
    .vlen    (vlen),
    .rd_a    (rd_a),
    .rd_b    (rd_b),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .done    (done)
);

// File: tb/vcs_unit_test.sv
module vcs_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] opcode = 3'd0;
    logic       density = 1'b0;
    logic [3:0] vlen = 4'd0;
    logic [2:0] rd_idx;
    logic [7:0] rd_a, rd_b;
    logic       wr_en;
    logic [2:0] wr_idx;
    logic [7:0] wr_data;
    logic       done;

    logic [7:0] va [8];
    logic [7:0] vb [8];
    logic [7:0] vc [8];
    logic [7:0] mm;
    logic [15:0] lf = 16'hACE1;

    int nchk = 0;
    int nfail = 0;
    int busy, nw;
    int widx [16];
    logic [7:0] wdat [16];

    always #4 clk = ~clk;

    assign rd_a = va[rd_idx];
    assign rd_b = vb[rd_idx];

    vcs_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .density(density), .vlen(vlen), .rd_idx(rd_idx), .rd_a(rd_a),
        .rd_b(rd_b), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    function automatic logic [7:0] f_arith(input int op, input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = a * b;
        case (op)
            4: return a + b;
            5: return p[7:0];
            6: return a;
            default: return b;
        endcase
    endfunction

    function automatic logic f_test(input int op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            0: return a == 8'd0;
            1: return a != 8'd0;
            default: return $signed(a) >= $signed(b);
        endcase
    endfunction

    task automatic run_op(input int op, input bit dens, input int len, input bit poke);
        bit seen;
        seen = 0;
        @(negedge clk);
        opcode = 3'(op); density = dens; vlen = 4'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy = 0; nw = 0;
        for (int k = 0; k < 64; k++) begin
            if (done) begin seen = 1; break; end
            busy++;
            if (wr_en) begin
                if (nw < 16) begin widx[nw] = int'(wr_idx); wdat[nw] = wr_data; end
                vc[wr_idx] = wr_data;
                nw++;
            end
            if (poke && k == 1) begin start = 1'b1; opcode = 3'd3; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen, "R10 done reached", int'(seen), 1);
        @(negedge clk);
        chk(!done, "R10 done lasts one cycle", int'(done), 0);
    endtask

    task automatic verify(input int op, input bit dens, input int len, input string tag);
        int L, lo, cnt, expb;
        int ei [8];
        logic [7:0] ed [8];
        L  = (len > 8) ? 8 : len;
        lo = (L == 0) ? 1 : L;
        if (op <= 2) begin
            chk(busy == lo, "R11 test duration", busy, lo);
            chk(nw == 0, "R11 test writes nothing", nw, 0);
            mm = 8'd0;
            for (int i = 0; i < L; i++) mm[i] = f_test(op, va[i], vb[i]);
        end else if (op == 3) begin
            chk(busy == 1, "R5 flip duration", busy, 1);
            chk(nw == 0, "R5 flip writes nothing", nw, 0);
            for (int i = 0; i < 8; i++) mm[i] = (i < L) ? ~mm[i] : 1'b0;
        end else begin
            cnt = 0;
            for (int i = 0; i < L; i++) begin
                if (mm[i]) begin
                    ei[cnt] = i; ed[cnt] = f_arith(op, va[i], vb[i]); cnt++;
                end
            end
            expb = dens ? ((cnt == 0) ? 1 : cnt) : lo;
            chk(busy == expb, dens ? "R7 density duration" : "R6 simple duration", busy, expb);
            chk(nw == cnt, {tag, " R9 write count"}, nw, cnt);
            for (int k = 0; k < cnt && k < nw && k < 16; k++) begin
                chk(widx[k] == ei[k], {tag, " element order"}, widx[k], ei[k]);
                chk(wdat[k] == ed[k], "R8 write data", int'(wdat[k]), int'(ed[k]));
            end
        end
    endtask

    task automatic do_op(input int op, input bit dens, input int len, input string tag);
        run_op(op, dens, len, 1'b0);
        verify(op, dens, len, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R10 watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 8; i++) begin va[i] = 8'd0; vb[i] = 8'd0; vc[i] = 8'd0; end
        mm = 8'd0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done low in reset", int'(done), 0);
        chk(wr_en == 1'b0, "R1 no write in reset", int'(wr_en), 0);
        rst_n = 1'b1;
        // R1: mask starts clear, so a simple move writes nothing
        for (int i = 0; i < 8; i++) begin va[i] = 8'(i + 1); vb[i] = 8'(i + 2); end
        do_op(6, 1'b0, 8, "R1");

        // R2 R3 R4 R6 R7 R8 R9 R5: sweep tests, probes and arithmetic
        for (int t = 0; t < 150; t++) begin
            for (int i = 0; i < 8; i++) begin
                step_lfsr();
                va[i] = (lf[3:1] == 3'd0) ? 8'd0 : lf[15:8];
                step_lfsr();
                vb[i] = (lf[2:0] == 3'd0) ? va[i] : lf[15:8];
            end
            do_op(t % 3, t[0], t % 11, "R2");
            do_op(6, 1'b0, 8, (t % 3 == 0) ? "R2" : (t % 3 == 1) ? "R3" : "R4");
            do_op(4 + (t % 4), ((t / 3) % 2) == 1, (t * 7) % 11, "R6");
            do_op(3, 1'b0, t % 9, "R5");
            do_op(4 + ((t + 1) % 4), ((t / 3) % 2) == 0, (t * 5) % 11, "R7");
            do_op(6, 1'b1, 15, "R9");
        end

        // R12: conditional select in both modes
        for (int md = 0; md < 2; md++) begin
            va[0] = 8'd1;   vb[0] = 8'd2;
            va[1] = 8'd2;   vb[1] = 8'd2;
            va[2] = 8'd3;   vb[2] = 8'd2;
            va[3] = 8'd4;   vb[3] = 8'd10;
            va[4] = 8'hFB;  vb[4] = 8'hFC;
            va[5] = 8'd0;   vb[5] = 8'hFD;
            va[6] = 8'd6;   vb[6] = 8'd5;
            va[7] = 8'hF9;  vb[7] = 8'hF8;
            for (int i = 0; i < 8; i++) vc[i] = 8'h55;
            do_op(2, 1'b0, 8, "R12");
            do_op(6, md == 1, 8, "R12");
            do_op(3, 1'b0, 8, "R12");
            do_op(7, md == 1, 8, "R12");
            for (int i = 0; i < 8; i++) begin
                logic [7:0] mx;
                mx = ($signed(va[i]) >= $signed(vb[i])) ? va[i] : vb[i];
                chk(vc[i] == mx, "R12 select result", int'(vc[i]), int'(mx));
            end
        end

        // R7: empty mask in density mode takes one cycle, no writes
        for (int i = 0; i < 8; i++) begin va[i] = 8'd1; vb[i] = 8'd50; end
        do_op(2, 1'b0, 8, "R4");
        do_op(4, 1'b1, 8, "R7");
        do_op(4, 1'b0, 0, "R6");

        // R10: start while busy is ignored; mask unchanged afterwards
        for (int i = 0; i < 8; i++) begin va[i] = (i % 3 == 0) ? 8'd0 : 8'(i); vb[i] = 8'(3 * i); end
        do_op(0, 1'b0, 8, "R2");
        run_op(4, 1'b0, 8, 1'b1);
        verify(4, 1'b0, 8, "R10");
        do_op(6, 1'b0, 8, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule